// File: doc/BRIEF.md
# Exception Priority Masking Unit

This block holds the three registers that decide whether a candidate exception may be taken right now: a one-bit global interrupt mask, a one-bit fault mask and a base-priority threshold. Each register can be changed through dedicated strobes or through a register-move port that also reads any of them back. From these registers the block gives a combinational "may be taken" decision for one candidate at a time, described by its priority and its class.

The global mask blocks ordinary interrupts only. The fault mask blocks ordinary interrupts and the hard fault. The non-maskable class always passes. A nonzero threshold blocks ordinary interrupts whose priority is numerically at or above the threshold, and a threshold of zero switches threshold masking off. Only the upper `IMPL_BITS` bits of an `PRIO_W`-bit priority are implemented. An exception-return pulse clears the fault mask. Software saves the threshold by reading it, raises it, and later writes the saved value back.

Top module: `prio_mask_unit`

## Requirements
- R1: After reset all three registers are zero, every readback returns 0 and every candidate class is taken.
- R2: With the global mask set, an ordinary interrupt (class 0 or 3) is blocked, while a hard fault (class 1) and a non-maskable candidate (class 2) are taken.
- R3: With the fault mask set, both ordinary interrupts and the hard fault are blocked.
- R4: An `excReturn` pulse clears the fault mask from the next cycle onward and leaves the global mask and the threshold unchanged.
- R5: A threshold of zero blocks no candidate, whatever its priority.
- R6: A nonzero threshold blocks an ordinary interrupt whose implemented priority is greater than or equal to the threshold and passes one that is smaller. The threshold has no effect on a hard fault.
- R7: A set strobe writes a 1 and a clear strobe writes a 0 into its mask bit. When both strobes arrive in the same cycle, the clear wins. With no write source active, a bit holds its value.
- R8: The move port selects a register with `mvSel`: 0 is the global mask, 1 is the fault mask, 2 is the threshold and 3 is unused. A mask write stores data bit 0 only, and a mask read returns the bit in bit 0 with the upper bits zero. Select 3 reads zero and a write to it has no effect.
- R9: The threshold reads back as the value last written, with the low `PRIO_W-IMPL_BITS` bits forced to zero. For the defaults 8/4, a write of 0x5A reads 0x50. Writing back a value that was read restores the threshold exactly. `thrOut` always shows the threshold.
- R10: The threshold comparison ignores the unimplemented low bits of the candidate priority. With threshold 0x50, priority 0x5F is blocked and priority 0x4F is taken.
- R11: For fault-mask writes the order of precedence is exception return, then clear strobe, then set strobe, then move-port write. The global mask follows the same order without the exception return.
- R12: A non-maskable candidate (class 2) is taken in every register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| gmSet | input | 1 | Global mask set strobe |
| gmClr | input | 1 | Global mask clear strobe |
| fmSet | input | 1 | Fault mask set strobe |
| fmClr | input | 1 | Fault mask clear strobe |
| mvWrEn | input | 1 | Move-port write enable |
| mvSel | input | 2 | Move-port register select (read and write) |
| mvWrData | input | PRIO_W | Move-port write data |
| mvRdData | output | PRIO_W | Move-port read data of the selected register |
| excReturn | input | 1 | Exception-return pulse |
| candPrio | input | PRIO_W | Candidate priority, MSB aligned |
| candClass | input | 2 | Candidate class: 0 interrupt, 1 hard fault, 2 non-maskable, 3 interrupt |
| takeOk | output | 1 | Candidate may be taken |
| thrOut | output | PRIO_W | Current threshold value |

## Verification
A mask bit stuck in the wrong state shows at `takeOk` in the cycle after the write that should have changed it. It also shows on `mvRdData` when the bench selects that register. A fault mask that does not clear on exception return keeps the hard fault blocked for one cycle or more. A threshold that keeps its low bits, or that is compared on full-width priorities, shows up at a boundary priority one step below the threshold. For that reason the bench probes both sides of each threshold and the priorities that differ only in unimplemented bits. Write-precedence faults only appear when strobes collide, so the bench drives colliding strobes on purpose.

// File: rtl/prio_mask_pkg.sv
package prio_mask_pkg;

  typedef enum logic [1:0] {
    CLS_IRQ  = 2'd0,
    CLS_HARD = 2'd1,
    CLS_NMI  = 2'd2,
    CLS_RSVD = 2'd3
  } excClass_e;

  typedef enum logic [1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_FAULT  = 2'd1,
    SEL_THR    = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // Resolved write commands from control to datapath
  typedef struct packed {
    logic gmWe;
    logic gmD;
    logic fmWe;
    logic fmD;
    logic thrWe;
  } maskWr_t;

endpackage

// File: rtl/prio_mask_ctrl.sv
module prio_mask_ctrl
  import prio_mask_pkg::*;
(
  input  logic       gmSet,
  input  logic       gmClr,
  input  logic       fmSet,
  input  logic       fmClr,
  input  logic       mvWrEn,
  input  logic [1:0] mvSel,
  input  logic       mvBit,
  input  logic       excReturn,
  output maskWr_t    wrCmd
);

  logic mvGm;
  logic mvFm;

  always_comb begin
    mvGm = mvWrEn && (regSel_e'(mvSel) == SEL_GLOBAL);
    mvFm = mvWrEn && (regSel_e'(mvSel) == SEL_FAULT);

    wrCmd = '0;

    // global mask: clear > set > move
    wrCmd.gmWe = gmClr | gmSet | mvGm;
    if (gmClr)      wrCmd.gmD = 1'b0;
    else if (gmSet) wrCmd.gmD = 1'b1;
    else            wrCmd.gmD = mvBit;

    // fault mask: exception return > clear > set > move
    wrCmd.fmWe = excReturn | fmClr | fmSet | mvFm;
    if (excReturn || fmClr) wrCmd.fmD = 1'b0;
    else if (fmSet)         wrCmd.fmD = 1'b1;
    else                    wrCmd.fmD = mvBit;

    wrCmd.thrWe = mvWrEn && (regSel_e'(mvSel) == SEL_THR);
  end

endmodule

// File: rtl/prio_mask_dp.sv
module prio_mask_dp
  import prio_mask_pkg::*;
#(
  parameter int PRIO_W    = 8,
  parameter int IMPL_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  maskWr_t           wrCmd,
  input  logic [PRIO_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  output logic [PRIO_W-1:0] rdData,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [1:0]        candClass,
  output logic              takeOk,
  output logic              gmQ,
  output logic              fmQ,
  output logic [PRIO_W-1:0] thrQ
);

  localparam int LOW_BITS = PRIO_W - IMPL_BITS;
  localparam logic [PRIO_W-1:0] IMPL_MASK = {{IMPL_BITS{1'b1}}, {LOW_BITS{1'b0}}};

  logic [PRIO_W-1:0] prioEff;
  logic              thrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gmQ  <= 1'b0;
      fmQ  <= 1'b0;
      thrQ <= '0;
    end else begin
      if (wrCmd.gmWe)  gmQ  <= wrCmd.gmD;
      if (wrCmd.fmWe)  fmQ  <= wrCmd.fmD;
      if (wrCmd.thrWe) thrQ <= wrData & IMPL_MASK;
    end
  end

  always_comb begin
    unique case (regSel_e'(rdSel))
      SEL_GLOBAL: rdData = {{(PRIO_W-1){1'b0}}, gmQ};
      SEL_FAULT:  rdData = {{(PRIO_W-1){1'b0}}, fmQ};
      SEL_THR:    rdData = thrQ;
      default:    rdData = '0;
    endcase
  end

  always_comb begin
    prioEff = candPrio & IMPL_MASK;
    thrHit  = (thrQ != '0) && (prioEff >= thrQ);
    unique case (excClass_e'(candClass))
      CLS_NMI:  takeOk = 1'b1;
      CLS_HARD: takeOk = !fmQ;
      default:  takeOk = !(gmQ || fmQ || thrHit);
    endcase
  end

endmodule

// File: rtl/prio_mask_unit.sv
module prio_mask_unit
  import prio_mask_pkg::*;
#(
  parameter int PRIO_W    = 8,
  parameter int IMPL_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              gmSet,
  input  logic              gmClr,
  input  logic              fmSet,
  input  logic              fmClr,
  input  logic              mvWrEn,
  input  logic [1:0]        mvSel,
  input  logic [PRIO_W-1:0] mvWrData,
  output logic [PRIO_W-1:0] mvRdData,
  input  logic              excReturn,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [1:0]        candClass,
  output logic              takeOk,
  output logic [PRIO_W-1:0] thrOut
);

  maskWr_t           wrCmd;
  logic              gmQ;
  logic              fmQ;
  logic [PRIO_W-1:0] thrQ;

  prio_mask_ctrl u_ctrl (
    .gmSet     (gmSet),
    .gmClr     (gmClr),
    .fmSet     (fmSet),
    .fmClr     (fmClr),
    .mvWrEn    (mvWrEn),
    .mvSel     (mvSel),
    .mvBit     (mvWrData[0]),
    .excReturn (excReturn),
    .wrCmd     (wrCmd)
  );

  prio_mask_dp #(.PRIO_W(PRIO_W), .IMPL_BITS(IMPL_BITS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrCmd     (wrCmd),
    .wrData    (mvWrData),
    .rdSel     (mvSel),
    .rdData    (mvRdData),
    .candPrio  (candPrio),
    .candClass (candClass),
    .takeOk    (takeOk),
    .gmQ       (gmQ),
    .fmQ       (fmQ),
    .thrQ      (thrQ)
  );

  assign thrOut = thrQ;

endmodule

// File: rtl/prio_mask_checker.sv
module prio_mask_checker #(
  parameter int PRIO_W    = 8,
  parameter int IMPL_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              gmSet,
  input logic              gmClr,
  input logic              fmSet,
  input logic              fmClr,
  input logic              mvWrEn,
  input logic [1:0]        mvSel,
  input logic              excReturn,
  input logic [PRIO_W-1:0] candPrio,
  input logic [1:0]        candClass,
  input logic              takeOk,
  input logic              gmQ,
  input logic              fmQ,
  input logic [PRIO_W-1:0] thrQ
);

  localparam int LOW_BITS = PRIO_W - IMPL_BITS;
  localparam logic [PRIO_W-1:0] IMPL_MASK = {{IMPL_BITS{1'b1}}, {LOW_BITS{1'b0}}};

  p_nmi_pass_r12: assert property (@(posedge clk) disable iff (!rstN)
    (candClass == 2'd2) |-> takeOk);

  p_global_blocks_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gmQ && (candClass == 2'd0 || candClass == 2'd3)) |-> !takeOk);

  p_fault_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fmQ && candClass != 2'd2) |-> !takeOk);

  p_exit_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    excReturn |=> !fmQ);

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (gmSet && gmClr) |=> !gmQ);

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!fmSet && !fmClr && !excReturn && !(mvWrEn && mvSel == 2'd1)) |=> $stable(fmQ));

  p_thr_low_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((thrQ & ~IMPL_MASK) == '0));

  p_thr_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (thrQ == '0 && !gmQ && !fmQ) |-> takeOk);

endmodule

bind prio_mask_unit prio_mask_checker #(.PRIO_W(PRIO_W), .IMPL_BITS(IMPL_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gmSet     (gmSet),
  .gmClr     (gmClr),
  .fmSet     (fmSet),
  .fmClr     (fmClr),
  .mvWrEn    (mvWrEn),
  .mvSel     (mvSel),
  .excReturn (excReturn),
  .candPrio  (candPrio),
  .candClass (candClass),
  .takeOk    (takeOk),
  .gmQ       (gmQ),
  .fmQ       (fmQ),
  .thrQ      (thrQ)
);

// File: tb/prio_mask_unit_test.sv
module prio_mask_unit_test;

  localparam int PERIOD = 10;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gmSet = 0, gmClr = 0, fmSet = 0, fmClr = 0, mvWrEn = 0, excReturn = 0;
  logic [1:0] mvSel = 0;
  logic [PW-1:0] mvWrData = 0;
  logic [PW-1:0] mvRdData;
  logic [PW-1:0] candPrio = 0;
  logic [1:0] candClass = 0;
  logic takeOk;
  logic [PW-1:0] thrOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic          take;
    logic [PW-1:0] rd;
    logic [PW-1:0] thr;
    string         req;
  } expItem_t;

  expItem_t expQ[$];

  // bench-side model of the registers
  logic mGm = 0, mFm = 0;
  logic [PW-1:0] mThr = 0;

  always #(PERIOD/2) clk = ~clk;

  prio_mask_unit uut (
    .clk(clk), .rstN(rstN), .gmSet(gmSet), .gmClr(gmClr), .fmSet(fmSet), .fmClr(fmClr),
    .mvWrEn(mvWrEn), .mvSel(mvSel), .mvWrData(mvWrData), .mvRdData(mvRdData),
    .excReturn(excReturn), .candPrio(candPrio), .candClass(candClass),
    .takeOk(takeOk), .thrOut(thrOut)
  );

  function automatic logic modelTake(logic [PW-1:0] p, logic [1:0] c);
    logic hit;
    hit = (mThr != 0) && ((p & 8'hF0) >= mThr);
    if (c == 2'd2) return 1'b1;
    if (c == 2'd1) return !mFm;
    return !(mGm || mFm || hit);
  endfunction

  function automatic logic [PW-1:0] modelRd(logic [1:0] s);
    case (s)
      2'd0: return {7'd0, mGm};
      2'd1: return {7'd0, mFm};
      2'd2: return mThr;
      default: return '0;
    endcase
  endfunction

  // driver: one write cycle, model follows the requirement precedence (R7, R8, R11)
  task automatic drive(input logic gs, gc, fs, fc, we, input logic [1:0] s,
                       input logic [PW-1:0] d, input logic er);
    @(negedge clk);
    gmSet = gs; gmClr = gc; fmSet = fs; fmClr = fc;
    mvWrEn = we; mvSel = s; mvWrData = d; excReturn = er;
    if (gc) mGm = 0; else if (gs) mGm = 1; else if (we && s == 2'd0) mGm = d[0];
    if (er || fc) mFm = 0; else if (fs) mFm = 1; else if (we && s == 2'd1) mFm = d[0];
    if (we && s == 2'd2) mThr = d & 8'hF0;
  endtask

  // driver: observation cycle, pushes expected item
  task automatic observe(input logic [PW-1:0] p, input logic [1:0] c,
                         input logic [1:0] s, input string req);
    expItem_t it;
    @(negedge clk);
    gmSet = 0; gmClr = 0; fmSet = 0; fmClr = 0; mvWrEn = 0; excReturn = 0;
    mvSel = s; candPrio = p; candClass = c;
    it.take = modelTake(p, c);
    it.rd = modelRd(s);
    it.thr = mThr;
    it.req = req;
    expQ.push_back(it);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (takeOk !== it.take || mvRdData !== it.rd || thrOut !== it.thr) begin
          errors++;
          $display("FAIL %s: take=%0b rd=%h thr=%h expected take=%0b rd=%h thr=%h",
                   it.req, takeOk, mvRdData, thrOut, it.take, it.rd, it.thr);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] saved;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    observe(8'hE0, 2'd0, 2'd0, "R1");
    observe(8'hE0, 2'd1, 2'd1, "R1");
    observe(8'hE0, 2'd2, 2'd2, "R1");
    // R2 global mask
    drive(1,0,0,0,0,0,0,0);
    observe(8'h00, 2'd0, 2'd0, "R2");
    observe(8'h00, 2'd3, 2'd0, "R2");
    observe(8'hF0, 2'd1, 2'd0, "R2");
    observe(8'hF0, 2'd2, 2'd0, "R12");
    // R7 clear, and colliding strobes
    drive(0,1,0,0,0,0,0,0);
    observe(8'h00, 2'd0, 2'd0, "R7");
    drive(1,1,0,0,0,0,0,0);
    observe(8'h00, 2'd0, 2'd0, "R7");
    // R3 fault mask
    drive(0,0,1,0,0,0,0,0);
    observe(8'h00, 2'd0, 2'd1, "R3");
    observe(8'h00, 2'd1, 2'd1, "R3");
    observe(8'h00, 2'd2, 2'd1, "R12");
    // R4 exception return clears fault mask only
    drive(1,0,0,0,0,0,0,0);
    drive(0,0,0,0,0,0,0,1);
    observe(8'h00, 2'd1, 2'd1, "R4");
    observe(8'h00, 2'd0, 2'd0, "R4");
    drive(0,1,0,0,0,0,0,0);
    // R11 precedence
    drive(0,0,1,0,0,0,0,1);
    observe(8'h00, 2'd1, 2'd1, "R11");
    drive(0,0,1,0,1,2'd1,8'h00,0);
    observe(8'h00, 2'd1, 2'd1, "R11");
    drive(0,0,0,1,0,0,0,0);
    drive(0,1,0,0,1,2'd0,8'h01,0);
    observe(8'h00, 2'd0, 2'd0, "R11");
    // R8 move port
    drive(0,0,0,0,1,2'd1,8'hFF,0);
    observe(8'h00, 2'd1, 2'd1, "R8");
    drive(0,0,0,0,1,2'd1,8'hFE,0);
    observe(8'h00, 2'd1, 2'd1, "R8");
    drive(0,0,0,0,1,2'd0,8'h03,0);
    observe(8'h00, 2'd0, 2'd0, "R8");
    drive(0,0,0,0,1,2'd0,8'h00,0);
    drive(0,0,0,0,1,2'd3,8'hFF,0);
    observe(8'h00, 2'd0, 2'd3, "R8");
    observe(8'hF0, 2'd0, 2'd2, "R8");
    // R6 threshold
    drive(0,0,0,0,1,2'd2,8'h60,0);
    observe(8'h60, 2'd0, 2'd2, "R6");
    observe(8'h50, 2'd0, 2'd2, "R6");
    observe(8'h70, 2'd3, 2'd2, "R6");
    observe(8'hF0, 2'd1, 2'd2, "R6");
    // R9 / R10 low bits
    drive(0,0,0,0,1,2'd2,8'h5A,0);
    observe(8'h5F, 2'd0, 2'd2, "R9");
    observe(8'h5F, 2'd0, 2'd2, "R10");
    observe(8'h4F, 2'd0, 2'd2, "R10");
    // R9 save, raise, restore
    saved = mThr;
    drive(0,0,0,0,1,2'd2,8'h20,0);
    observe(8'h10, 2'd0, 2'd2, "R9");
    observe(8'h20, 2'd0, 2'd2, "R9");
    drive(0,0,0,0,1,2'd2,saved,0);
    observe(8'h50, 2'd0, 2'd2, "R9");
    // R5 zero threshold
    drive(0,0,0,0,1,2'd2,8'h0F,0);
    observe(8'hF0, 2'd0, 2'd2, "R5");
    observe(8'hFF, 2'd3, 2'd2, "R5");
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule